// File: doc/BRIEF.md
# Hook State Detector with Filtered Threshold and Debounce

This block decides whether a telephone line is off-hook or has tripped the ringer. It takes a signed stream of samples, either loop current or tip-to-ring voltage as chosen by a source-select input. Each sample is smoothed by a first-order low-pass filter with a programmable coefficient, which strips AC ripple such as ringing. The smoothed value is then compared with a programmable signed threshold.

The comparator output is visible directly as a raw bit. It also feeds a debouncer, which changes the reported state only after the comparator has disagreed with that state for a programmable number of consecutive samples. Each change of the reported state raises a single-cycle interrupt request. The analog front end and the converter that produces the samples lie outside this block.

Top module: `hook_detector`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), the filter state is 0, `det` is 0, `chg_irq` is 0 and the debounce interval is 10 samples.
- R2: With `src_volt` = 1 the filter takes `smp_volt`, and with `src_volt` = 0 it takes `smp_cur`; the sample not selected has no effect.
- R3: On every clock edge with `smp_valid` high, the filter state y becomes sat16(y + ((coef × (x − y)) >>> 15)), using signed arithmetic and an arithmetic right shift. When `smp_valid` is low, y holds its value.
- R4: `raw_det` equals (y > `thresh`) as a signed comparison. It reflects a new sample in the cycle after the edge that takes the sample, and it follows a change of `thresh` without delay.
- R5: One cycle after each sample edge, the sample is evaluated. If `raw_det` equals `det`, the run count clears. Otherwise the run count increments, and when it reaches N = max(interval, 1), `det` takes the value of `raw_det` and the count clears. Any agreeing sample restarts the run.
- R6: `chg_irq` is high for exactly one cycle, in the first cycle in which `det` shows a new value, and it is high at no other time.
- R7: A clock edge with `dbnc_we` high loads `dbnc_val` (7 bits) as the debounce interval, which applies to every later evaluation. An interval of 0 acts as 1.
- R8: A filter result above 32767 is clamped to 32767, and a result below −32768 is clamped to −32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | A new sample is present this cycle |
| smp_cur | input | 16 | Loop current sample, signed |
| smp_volt | input | 16 | Tip-to-ring voltage sample, signed |
| src_volt | input | 1 | 1 selects the voltage sample, 0 selects the current sample |
| coef | input | 16 | Filter coefficient, signed Q1.15 |
| thresh | input | 16 | Detection threshold, signed |
| dbnc_we | input | 1 | Load strobe for the debounce interval |
| dbnc_val | input | 7 | New debounce interval, in samples |
| raw_det | output | 1 | Comparator output, not debounced |
| det | output | 1 | Debounced hook state |
| chg_irq | output | 1 | One-cycle pulse on each change of `det` |

## Verification
A wrong filter state shows first on `raw_det`, in the cycle after the sample that corrupts it. Driving the filtered value close to the threshold makes even a one-LSB error in rounding or saturation flip that bit. A wrong run count or interval does not show until the last sample of a run: `det` and `chg_irq` then change one sample too early or too late. Runs that are interrupted just short of their length are therefore used to expose count errors within a few samples.

// File: rtl/hookdet_pkg.sv
package hookdet_pkg;

    // Debounced hook state
    typedef enum logic {
        HOOK_OPEN   = 1'b0,
        HOOK_CLOSED = 1'b1
    } hook_state_e;

    // Reset value of the debounce interval, in samples
    localparam int unsigned DBNC_RESET = 10;

    // Debouncer outputs as one bundle
    typedef struct packed {
        hook_state_e state;
        logic        change;
    } dbnc_out_t;

    // Effective run length: an interval of zero behaves as one
    function automatic int unsigned run_limit(input int unsigned ival);
        return (ival == 0) ? 1 : ival;
    endfunction

endpackage

// File: rtl/hookdet_lpf.sv
module hookdet_lpf #(
    parameter int W     = 16,
    parameter int KW    = 16,
    parameter int SHIFT = 15
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic signed [W-1:0] x,
    input  logic signed [KW-1:0] k,
    output logic signed [W-1:0] y
);
    localparam int DW = W + 1;     // width of the difference
    localparam int PW = DW + KW;   // width of the product
    localparam int SW = PW + 1;    // width of the sum

    logic signed [DW-1:0] diff;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] step;
    logic signed [SW-1:0] sum;
    logic signed [W-1:0]  nxt;

    always_comb begin
        diff = DW'(x) - DW'(y);
        prod = PW'(diff) * PW'(k);
        step = prod >>> SHIFT;
        sum  = SW'(y) + SW'(step);
        // Clamp to the signed range of W bits
        if (sum[SW-1] && !(&sum[SW-2:W-1]))
            nxt = {1'b1, {(W-1){1'b0}}};
        else if (!sum[SW-1] && (|sum[SW-2:W-1]))
            nxt = {1'b0, {(W-1){1'b1}}};
        else
            nxt = sum[W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            y <= '0;
        else if (en)
            y <= nxt;
    end
endmodule

// File: rtl/hookdet_debounce.sv
module hookdet_debounce
    import hookdet_pkg::*;
#(
    parameter int CW   = 7,
    parameter int DFLT = DBNC_RESET
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          eval,
    input  logic          raw,
    input  logic          ld,
    input  logic [CW-1:0] ld_val,
    output dbnc_out_t     dout
);
    localparam int LW = CW + 1;

    logic [CW-1:0] ival;
    logic [CW-1:0] cnt;
    logic [LW-1:0] lim;
    logic [LW-1:0] cnt_inc;

    always_comb begin
        lim     = LW'(run_limit(int'(ival)));
        cnt_inc = LW'(cnt) + LW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)
            ival <= CW'(DFLT);
        else if (ld)
            ival <= ld_val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt         <= '0;
            dout.state  <= HOOK_OPEN;
            dout.change <= 1'b0;
        end else begin
            dout.change <= 1'b0;
            if (eval) begin
                if (raw == logic'(dout.state)) begin
                    cnt <= '0;
                end else if (cnt_inc >= lim) begin
                    cnt         <= '0;
                    dout.state  <= hook_state_e'(raw);
                    dout.change <= 1'b1;
                end else begin
                    cnt <= cnt_inc[CW-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/hook_detector.sv
module hook_detector
    import hookdet_pkg::*;
#(
    parameter int W     = 16,
    parameter int KW    = 16,
    parameter int SHIFT = 15,
    parameter int CW    = 7
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 smp_valid,
    input  logic signed [W-1:0]  smp_cur,
    input  logic signed [W-1:0]  smp_volt,
    input  logic                 src_volt,
    input  logic signed [KW-1:0] coef,
    input  logic signed [W-1:0]  thresh,
    input  logic                 dbnc_we,
    input  logic [CW-1:0]        dbnc_val,
    output logic                 raw_det,
    output logic                 det,
    output logic                 chg_irq
);
    logic signed [W-1:0] src_smp;
    logic signed [W-1:0] filt;
    logic                eval_q;
    dbnc_out_t           dbo;

    assign src_smp = src_volt ? smp_volt : smp_cur;

    hookdet_lpf #(.W(W), .KW(KW), .SHIFT(SHIFT)) u_lpf (
        .clk (clk),
        .rst (rst),
        .en  (smp_valid),
        .x   (src_smp),
        .k   (coef),
        .y   (filt)
    );

    assign raw_det = (filt > thresh);

    // Evaluation happens one cycle after the filter takes a sample
    always_ff @(posedge clk) begin
        if (rst)
            eval_q <= 1'b0;
        else
            eval_q <= smp_valid;
    end

    hookdet_debounce #(.CW(CW)) u_dbnc (
        .clk    (clk),
        .rst    (rst),
        .eval   (eval_q),
        .raw    (raw_det),
        .ld     (dbnc_we),
        .ld_val (dbnc_val),
        .dout   (dbo)
    );

    assign det     = logic'(dbo.state);
    assign chg_irq = dbo.change;
endmodule

// File: rtl/hookdet_chk.sv
module hookdet_chk #(
    parameter int W = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                smp_valid,
    input logic signed [W-1:0] thresh,
    input logic                raw_det,
    input logic                det,
    input logic                chg_irq
);
    // R1: reset clears the reported state and the request
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!det && !chg_irq));

    // R4: without a sample or a threshold change, the raw bit holds
    a_r4_raw_holds: assert property (@(posedge clk) disable iff (rst)
        (!$past(smp_valid) && $stable(thresh)) |-> $stable(raw_det));

    // R5: the reported state moves only one cycle after a sample edge
    a_r5_det_after_sample: assert property (@(posedge clk) disable iff (rst)
        !$past(smp_valid, 2) |-> $stable(det));

    // R5: a new reported state takes the comparator value
    a_r5_det_takes_raw: assert property (@(posedge clk) disable iff (rst)
        (det != $past(det)) |-> (det == $past(raw_det)));

    // R6: a request marks a change of state
    a_r6_irq_means_change: assert property (@(posedge clk) disable iff (rst)
        chg_irq |-> (det != $past(det)));

    // R6: every change of state raises a request
    a_r6_change_means_irq: assert property (@(posedge clk) disable iff (rst)
        (det != $past(det)) |-> chg_irq);
endmodule

bind hook_detector hookdet_chk #(.W(W)) i_hookdet_chk (
    .clk       (clk),
    .rst       (rst),
    .smp_valid (smp_valid),
    .thresh    (thresh),
    .raw_det   (raw_det),
    .det       (det),
    .chg_irq   (chg_irq)
);

// File: tb/test_hook_detector.sv
module test_hook_detector;
    localparam int CLK_PER = 10;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               smp_valid = 1'b0;
    logic signed [15:0] smp_cur = '0;
    logic signed [15:0] smp_volt = '0;
    logic               src_volt = 1'b0;
    logic signed [15:0] coef = '0;
    logic signed [15:0] thresh = 16'sd100;
    logic               dbnc_we = 1'b0;
    logic [6:0]         dbnc_val = '0;
    logic               raw_det, det, chg_irq;

    hook_detector i_hook_detector (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_cur(smp_cur),
        .smp_volt(smp_volt), .src_volt(src_volt), .coef(coef),
        .thresh(thresh), .dbnc_we(dbnc_we), .dbnc_val(dbnc_val),
        .raw_det(raw_det), .det(det), .chg_irq(chg_irq)
    );

    always #(CLK_PER/2) clk = ~clk;

    typedef struct {
        logic  raw;
        logic  det;
        logic  irq;
        string tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_fail = 0;

    // Reference model state
    int   my = 0;
    logic mdet = 1'b0;
    int   mcnt = 0;
    int   mdb = 10;

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: model the requirements, queue the result, drive one sample
    task automatic send(int xc, int xv, string tag);
        int     x;
        longint prod;
        logic   r;
        logic   irq;
        int     lim;
        x    = src_volt ? xv : xc;                          // R2
        prod = longint'(coef) * longint'(x - my);           // R3
        my   = my + int'(prod >>> 15);
        if (my > 32767)  my = 32767;                        // R8
        if (my < -32768) my = -32768;
        r    = (my > int'(thresh));                         // R4
        lim  = (mdb == 0) ? 1 : mdb;                        // R7
        irq  = 1'b0;
        if (r == mdet) mcnt = 0;                            // R5
        else if (mcnt + 1 >= lim) begin
            mdet = r; mcnt = 0; irq = 1'b1;                 // R6
        end else mcnt++;
        q.push_back('{raw: r, det: mdet, irq: irq, tag: tag});
        @(negedge clk);
        smp_cur = 16'(xc); smp_volt = 16'(xv); smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic set_dbnc(int v);
        @(negedge clk);
        dbnc_we = 1'b1; dbnc_val = 7'(v);
        @(negedge clk);
        dbnc_we = 1'b0;
        mdb = v;
    endtask

    // Monitor: bench-side delay of its own valid strobe
    logic vq1 = 1'b0, vq2 = 1'b0;
    always @(posedge clk) begin
        vq1 <= smp_valid;
        vq2 <= vq1;
    end

    always @(negedge clk) begin
        if (vq2 && !rst && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk({e.tag, " R4 raw"}, int'(raw_det), int'(e.raw));
            chk({e.tag, " R5 det"}, int'(det), int'(e.det));
            chk({e.tag, " R6 irq"}, int'(chg_irq), int'(e.irq));
        end
    end

    initial begin
        #(CLK_PER * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic prev;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 det", int'(det), 0);
        chk("R1 irq", int'(chg_irq), 0);
        chk("R1 raw", int'(raw_det), 0);

        // R1: default interval of 10 samples
        thresh = 16'sd1000;
        coef   = 16'sd32767;
        repeat (9) send(5000, 0, "R1");
        chk("R1 interval not yet", int'(det), 0);
        send(5000, 0, "R1");
        chk("R1 interval reached", int'(det), 1);
        repeat (10) send(0, 0, "R1 fall");

        // R7: shorter interval; R2: voltage source
        set_dbnc(3);
        src_volt = 1'b1;
        repeat (4) send(5000, -2000, "R2 volt");
        chk("R2 current ignored", int'(raw_det), 0);
        repeat (3) send(-2000, 5000, "R2 volt");
        chk("R7 interval 3", int'(det), 1);
        src_volt = 1'b0;

        // R5: an agreeing sample restarts the run
        send(0, 0, "R5");
        send(0, 0, "R5");
        send(5000, 0, "R5");
        send(0, 0, "R5");
        send(0, 0, "R5");
        chk("R5 restarted", int'(det), 1);
        send(0, 0, "R5");
        chk("R5 run done", int'(det), 0);

        // R7: interval 0 acts as 1
        set_dbnc(0);
        send(5000, 0, "R7");
        chk("R7 zero acts as one", int'(det), 1);

        // R4: negative threshold
        thresh = -16'sd100;
        send(-50, 0, "R4 neg");
        send(-150, 0, "R4 neg");

        // R3: samples without the strobe are ignored
        prev = raw_det;
        @(negedge clk);
        smp_cur = -16'sd30000;
        repeat (4) @(negedge clk);
        chk("R3 no strobe", int'(raw_det), int'(prev));

        // R3: slow coefficient
        thresh = 16'sd1000;
        coef   = 16'sd8192;
        repeat (8) send(4000, 0, "R3 k/4");

        // R8: saturation at both ends
        coef = 16'sd32767;
        repeat (3) send(32767, 0, "R8");
        coef = -16'sd32768;
        thresh = 16'sd32766;
        send(-32768, 0, "R8 max");
        coef = 16'sd32767;
        thresh = -16'sd32768;
        send(-32768, 0, "R8");
        coef = -16'sd32768;
        send(32767, 0, "R8 min");

        wait (q.size() == 0);
        @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule